// File: doc/BRIEF.md
# Framed Serial Transmitter with Enable Preamble

This block turns characters written by software into an asynchronous serial bit stream. A single holding register takes one character. The transmit shift register takes the character from it and clocks it onto the line, one bit for each pulse of an external baud tick. Each frame carries a low start bit, 8 or 9 data bits sent least significant bit first, and a high stop bit. When parity is on, a parity bit takes the place of the top data bit.

Each time the enable input rises, the block queues a run of marking ones as long as one frame. This run goes out ahead of the next character, so the receiver sees an idle line between messages. When the enable falls, the frame that is shifting finishes. The block then releases the line even if a character is still waiting in the holding register.

Flags report an empty holding register and an idle transmitter, and an interrupt request follows the empty flag when it is unmasked. An output-enable lets the pad go high-impedance.

Top module: `sertx_top`

## Requirements
- R1: After reset, with the enable low, tdre=1, tidle=1, txd_oe=0, irq=0 and txd=1.
- R2: A 0-to-1 change of tx_en queues a run of ones as long as a frame: 10 ones when wide_mode=0, 11 when wide_mode=1. The run loads at the first tick in or after the cycle of the rise, so L+1 ones are seen on the line before the first start bit.
- R3: Once the preamble has shifted out, the pending character moves into the shift register and tdre rises on that tick. A character written before the current frame ends follows it with no gap.
- R4: A frame is a 0 start bit, then the data LSB first (8 bits when wide_mode=0, 9 when wide_mode=1), then a 1 stop bit.
- R5: With par_en=1, the top data bit (bit 7 when wide_mode=0, bit 8 when wide_mode=1) is replaced by a parity bit over the lower bits. par_odd=0 makes the count of ones even and par_odd=1 makes it odd.
- R6: tdre clears only when a data_wr pulse follows a stat_rd pulse made while tdre=1. A data_wr without that read leaves tdre=1, and no character is sent.
- R7: irq is 1 exactly when tdre=1 and empty_ie=1.
- R8: While tx_en=1, txd_oe=1, and txd=1 whenever no preamble or frame is shifting.
- R9: If tx_en falls during a frame, the frame completes. A character still pending is not sent, tdre stays 0, and txd_oe falls after the stop bit.
- R10: Clearing and then setting tx_en queues a preamble. It goes out after the current frame and before the next character, and a character left pending while disabled is sent after it.
- R11: txd changes only on the clock edge that takes a baud tick, so each bit lasts one tick period.
- R12: tidle=1 only when nothing is shifting and no preamble or character load is waiting for an enabled transmitter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| baud_tick | input | 1 | One-cycle pulse per bit period |
| tx_en | input | 1 | Transmitter enable |
| wide_mode | input | 1 | 1 selects 9 data bits, 0 selects 8 |
| par_en | input | 1 | Parity replaces the top data bit |
| par_odd | input | 1 | 1 odd parity, 0 even parity |
| empty_ie | input | 1 | Interrupt mask for the empty flag |
| stat_rd | input | 1 | Status read strobe |
| data_wr | input | 1 | Data write strobe |
| data_in | input | DATA_W | Character to send |
| txd | output | 1 | Serial data out |
| txd_oe | output | 1 | Pad output enable |
| tdre | output | 1 | Holding register empty |
| tidle | output | 1 | Transmitter idle |
| irq | output | 1 | Transmit interrupt request |

## Verification
The assertions assume the following about the inputs. baud_tick, stat_rd and data_wr are one-cycle pulses. wide_mode, par_en and par_odd change only while tx_en is low and the pad is released. The bench keeps to this: it issues the ticks as single pulses every fourth cycle, and it draws a random format only after waiting for txd_oe to fall. It recomputes every frame bit and every parity value on its own from the character and the format.

// File: rtl/sertx_pkg.sv
package sertx_pkg;
   typedef enum logic [2:0] {
      LD_HOLD,
      LD_SHIFT,
      LD_PRE,
      LD_CHAR,
      LD_IDLE
   } ld_kind_e;

   function automatic logic par_of(input logic [15:0] bits, input logic odd);
      return (^bits) ^ odd;
   endfunction
endpackage

// File: rtl/sertx_framer.sv
module sertx_framer #(
   parameter int DATA_W    = 9,
   parameter bit PARITY_EN = 1'b1,
   parameter int FRAME_W   = DATA_W + 2,
   parameter int CNT_W     = $clog2(FRAME_W + 1)
) (
   input  logic [DATA_W-1:0]  data,
   input  logic               wide,
   input  logic               par_en,
   input  logic               par_odd,
   output logic [FRAME_W-1:0] frame,
   output logic [CNT_W-1:0]   flen
);
   localparam int TOP_WIDE   = DATA_W - 1;
   localparam int TOP_NARROW = DATA_W - 2;

   int unsigned        top_idx;
   logic [DATA_W-1:0]  below;
   logic [DATA_W-1:0]  payload;

   always_comb top_idx = wide ? TOP_WIDE : TOP_NARROW;

   always_comb begin
      for (int i = 0; i < DATA_W; i++) begin
         below[i] = data[i] & (i < top_idx);
      end
   end

   generate
      if (PARITY_EN) begin : g_par
         logic par_bit;
         assign par_bit = sertx_pkg::par_of(16'(below), par_odd);
         always_comb begin
            payload = data;
            if (!wide) payload[DATA_W-1] = 1'b1;
            if (par_en) payload[top_idx] = par_bit;
         end
      end else begin : g_nopar
         logic unused_par;
         assign unused_par = ^{par_en, par_odd, below};
         always_comb begin
            payload = data;
            if (!wide) payload[DATA_W-1] = 1'b1;
         end
      end
   endgenerate

   assign frame = {1'b1, payload, 1'b0};
   assign flen  = wide ? CNT_W'(FRAME_W) : CNT_W'(FRAME_W - 1);
endmodule

// File: rtl/sertx_holdreg.sv
module sertx_holdreg #(
   parameter int DATA_W = 9
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              stat_rd,
   input  logic              data_wr,
   input  logic [DATA_W-1:0] data_in,
   input  logic              take,
   output logic [DATA_W-1:0] hold_q,
   output logic              empty
);
   logic armed_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_q  <= '0;
         empty   <= 1'b1;
         armed_q <= 1'b0;
      end else begin
         if (data_wr) hold_q <= data_in;
         if (take) begin
            empty <= 1'b1;
         end else if (data_wr && armed_q && empty) begin
            empty   <= 1'b0;
            armed_q <= 1'b0;
         end else if (stat_rd && empty) begin
            armed_q <= 1'b1;
         end
      end
   end
endmodule

// File: rtl/sertx_shifter.sv
module sertx_shifter #(
   parameter int FRAME_W = 11,
   parameter int CNT_W   = $clog2(FRAME_W + 1)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               tick,
   input  logic               tx_en,
   input  logic               en_rise,
   input  logic               char_ready,
   input  logic [FRAME_W-1:0] frame_in,
   input  logic [CNT_W-1:0]   flen_in,
   output logic               take,
   output logic               bit_out,
   output logic               busy,
   output logic               pre_waiting
);
   import sertx_pkg::*;

   logic [FRAME_W-1:0] sh_q;
   logic [CNT_W-1:0]   cnt_q;
   logic               pre_q;
   logic               at_end;
   logic               pre_req;
   ld_kind_e           kind;

   assign at_end  = (cnt_q <= CNT_W'(1));
   assign pre_req = tx_en && (pre_q || en_rise);

   always_comb begin
      if (!tick)                    kind = LD_HOLD;
      else if (!at_end)             kind = LD_SHIFT;
      else if (pre_req)             kind = LD_PRE;
      else if (tx_en && char_ready) kind = LD_CHAR;
      else                          kind = LD_IDLE;
   end

   assign take = (kind == LD_CHAR);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q  <= '1;
         cnt_q <= '0;
      end else begin
         case (kind)
            LD_SHIFT: begin
               sh_q  <= {1'b1, sh_q[FRAME_W-1:1]};
               cnt_q <= cnt_q - CNT_W'(1);
            end
            LD_PRE: begin
               sh_q  <= '1;
               cnt_q <= flen_in;
            end
            LD_CHAR: begin
               sh_q  <= frame_in;
               cnt_q <= flen_in;
            end
            LD_IDLE: begin
               sh_q  <= '1;
               cnt_q <= '0;
            end
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              pre_q <= 1'b0;
      else if (!tx_en)         pre_q <= 1'b0;
      else if (kind == LD_PRE) pre_q <= 1'b0;
      else if (en_rise)        pre_q <= 1'b1;
   end

   assign busy        = (cnt_q != '0);
   assign bit_out     = busy ? sh_q[0] : 1'b1;
   assign pre_waiting = pre_q;
endmodule

// File: rtl/sertx_top.sv
module sertx_top #(
   parameter int DATA_W    = 9,
   parameter bit PARITY_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              baud_tick,
   input  logic              tx_en,
   input  logic              wide_mode,
   input  logic              par_en,
   input  logic              par_odd,
   input  logic              empty_ie,
   input  logic              stat_rd,
   input  logic              data_wr,
   input  logic [DATA_W-1:0] data_in,
   output logic              txd,
   output logic              txd_oe,
   output logic              tdre,
   output logic              tidle,
   output logic              irq
);
   localparam int FRAME_W = DATA_W + 2;
   localparam int CNT_W   = $clog2(FRAME_W + 1);

   generate
      if (DATA_W < 5 || DATA_W > 16) begin : g_bad_width
         $error("sertx_top: DATA_W must lie in 5..16");
      end
   endgenerate

   logic               en_q;
   logic               en_rise;
   logic [DATA_W-1:0]  hold_q;
   logic               empty;
   logic               take;
   logic [FRAME_W-1:0] frame;
   logic [CNT_W-1:0]   flen;
   logic               busy;
   logic               pre_waiting;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) en_q <= 1'b0;
      else        en_q <= tx_en;
   end
   assign en_rise = tx_en && !en_q;

   sertx_holdreg #(.DATA_W(DATA_W)) u_hold (
      .clk     (clk),
      .rst_n   (rst_n),
      .stat_rd (stat_rd),
      .data_wr (data_wr),
      .data_in (data_in),
      .take    (take),
      .hold_q  (hold_q),
      .empty   (empty)
   );

   sertx_framer #(
      .DATA_W    (DATA_W),
      .PARITY_EN (PARITY_EN),
      .FRAME_W   (FRAME_W),
      .CNT_W     (CNT_W)
   ) u_framer (
      .data    (hold_q),
      .wide    (wide_mode),
      .par_en  (par_en),
      .par_odd (par_odd),
      .frame   (frame),
      .flen    (flen)
   );

   sertx_shifter #(.FRAME_W(FRAME_W), .CNT_W(CNT_W)) u_shift (
      .clk         (clk),
      .rst_n       (rst_n),
      .tick        (baud_tick),
      .tx_en       (tx_en),
      .en_rise     (en_rise),
      .char_ready  (!empty),
      .frame_in    (frame),
      .flen_in     (flen),
      .take        (take),
      .bit_out     (txd),
      .busy        (busy),
      .pre_waiting (pre_waiting)
   );

   assign txd_oe = tx_en || busy;
   assign tdre   = empty;
   assign tidle  = !busy && !(tx_en && (pre_waiting || en_rise || !empty));
   assign irq    = empty && empty_ie;
endmodule

// File: rtl/sertx_chk.sv
module sertx_chk (
   input logic clk,
   input logic rst_n,
   input logic baud_tick,
   input logic tx_en,
   input logic empty_ie,
   input logic data_wr,
   input logic txd,
   input logic txd_oe,
   input logic tdre,
   input logic tidle,
   input logic irq
);
   AST_OE_WHILE_EN: assert property (@(posedge clk) disable iff (!rst_n)
      tx_en |-> txd_oe) else $error("oe low while enabled"); // R8
   AST_IDLE_MARK: assert property (@(posedge clk) disable iff (!rst_n)
      tidle |-> txd) else $error("line not marking when idle"); // R12
   AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
      (!tx_en && tidle) |-> !txd_oe) else $error("pin held after stop"); // R9
   AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
      !empty_ie |-> !irq) else $error("irq while masked"); // R7
   AST_IRQ_NEEDS_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> tdre) else $error("irq without empty flag"); // R7
   AST_EMPTY_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tdre) |-> $past(baud_tick)) else $error("transfer off tick"); // R3
   AST_FULL_BY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(tdre) |-> $past(data_wr)) else $error("flag cleared without write"); // R6
   AST_TXD_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(txd) |-> $past(baud_tick)) else $error("txd moved between ticks"); // R11
endmodule

bind sertx_top sertx_chk u_chk (.*);

// File: tb/sertx_top_tb.sv
module sertx_top_tb;
   localparam int DW = 9;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          tick = 1'b0;
   logic          tx_en = 1'b0;
   logic          wide = 1'b0;
   logic          pe = 1'b0;
   logic          po = 1'b0;
   logic          ie = 1'b0;
   logic          stat_rd = 1'b0;
   logic          data_wr = 1'b0;
   logic [DW-1:0] data_in = '0;
   logic          txd, txd_oe, tdre, tidle, irq;

   int n_chk = 0;
   int n_fail = 0;
   logic rec_q[$];
   logic exp_q[$];
   logic [DW-1:0] msg [4];

   sertx_top #(.DATA_W(DW)) u_dut (
      .clk(clk), .rst_n(rst_n), .baud_tick(tick), .tx_en(tx_en),
      .wide_mode(wide), .par_en(pe), .par_odd(po), .empty_ie(ie),
      .stat_rd(stat_rd), .data_wr(data_wr), .data_in(data_in),
      .txd(txd), .txd_oe(txd_oe), .tdre(tdre), .tidle(tidle), .irq(irq)
   );

   always #2 clk = ~clk;

   initial begin
      forever begin
         repeat (3) @(posedge clk);
         #1 tick = 1'b1;
         @(posedge clk);
         #1 tick = 1'b0;
      end
   end

   always @(negedge clk) if (tick) rec_q.push_back(txd);

   task automatic check(input bit ok, input string tag, input string what,
                        input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: %s actual=%0d expected=%0d", tag, what, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   task automatic wr_char(input logic [DW-1:0] d, input bit with_read);
      if (with_read) begin
         stat_rd = 1'b1;
         step();
         stat_rd = 1'b0;
      end
      data_wr = 1'b1;
      data_in = d;
      step();
      data_wr = 1'b0;
   endtask

   function automatic int pre_len();
      return wide ? 11 : 10;
   endfunction

   function automatic void push_ones(input int n);
      for (int i = 0; i < n; i++) exp_q.push_back(1'b1);
   endfunction

   function automatic void push_frame(input logic [DW-1:0] d);
      int nb = wide ? 9 : 8;
      int ones = 0;
      logic pbit;
      for (int i = 0; i < nb - 1; i++) ones += int'(d[i]);
      pbit = ((ones % 2) == 1) ^ po;
      exp_q.push_back(1'b0);
      for (int i = 0; i < nb; i++) exp_q.push_back((pe && i == nb - 1) ? pbit : d[i]);
      exp_q.push_back(1'b1);
   endfunction

   task automatic compare(input string tag);
      int bad = -1;
      if (rec_q.size() < exp_q.size()) bad = rec_q.size();
      else begin
         for (int i = 0; i < rec_q.size(); i++) begin
            logic e = (i < exp_q.size()) ? exp_q[i] : 1'b1;
            if (rec_q[i] !== e && bad < 0) bad = i;
         end
      end
      check(bad < 0, tag, "line stream first mismatch index", bad, -1);
   endtask

   task automatic settle();
      while (!tidle) step();
      repeat (12) step();
   endtask

   task automatic run_msg(input int n, input string tag);
      while (txd_oe) step();
      check(tdre == 1'b1, "R6", "tdre before message", tdre, 1);
      wr_char(msg[0], 1'b1);
      check(tdre == 1'b0, "R6", "tdre after read+write", tdre, 0);
      rec_q.delete();
      exp_q.delete();
      push_ones(pre_len() + 1);
      push_frame(msg[0]);
      tx_en = 1'b1;
      step();
      check(tidle == 1'b0, "R12", "tidle with load waiting", tidle, 0);
      for (int k = 1; k < n; k++) begin
         while (!tdre) step();
         wr_char(msg[k], 1'b1);
         push_frame(msg[k]);
      end
      settle();
      compare(tag);
      check(tdre == 1'b1, "R3", "tdre after last transfer", tdre, 1);
      check(irq == (tdre && ie), "R7", "irq vs mask", irq, tdre && ie);
      tx_en = 1'b0;
      step();
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      n_chk++;
      $display("FAIL watchdog: run did not finish actual=1 expected=0");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      void'($urandom(32'd4117));
      repeat (5) step();
      check(tdre == 1'b1 && tidle == 1'b1, "R1", "tdre&tidle at reset", {tdre, tidle}, 3);
      check(txd_oe == 1'b0 && irq == 1'b0, "R1", "oe|irq at reset", {txd_oe, irq}, 0);
      check(txd == 1'b1, "R1", "txd at reset", txd, 1);
      rst_n = 1'b1;
      step();

      ie = 1'b1;
      #1 check(irq == 1'b1, "R7", "irq unmasked with tdre", irq, 1);
      ie = 1'b0;
      #1 check(irq == 1'b0, "R7", "irq masked", irq, 0);

      // R6: a write with no status read first is not accepted
      wr_char(9'h000, 1'b0);
      check(tdre == 1'b1, "R6", "tdre after write without read", tdre, 1);
      rec_q.delete();
      exp_q.delete();
      push_ones(pre_len() + 1);
      tx_en = 1'b1;
      repeat (3) step();
      settle();
      compare("R2 R6 preamble only, char not sent");
      check(txd_oe == 1'b1 && txd == 1'b1, "R8", "enabled idle line", {txd_oe, txd}, 3);
      tx_en = 1'b0;
      step();
      check(txd_oe == 1'b0, "R8", "oe after disable while idle", txd_oe, 0);

      // R4 R5 directed formats
      wide = 1'b1; pe = 1'b0; po = 1'b0;
      msg[0] = 9'h1A5;
      run_msg(1, "R4 R11 nine-bit frame");
      wide = 1'b0; pe = 1'b1; po = 1'b0;
      msg[0] = 9'h0FF;
      run_msg(1, "R5 even parity 8-bit");
      wide = 1'b1; pe = 1'b1; po = 1'b1;
      msg[0] = 9'h0F0; msg[1] = 9'h1FF; msg[2] = 9'h000;
      run_msg(3, "R3 R5 odd parity back-to-back");

      // R9: disable during a frame with a character pending
      wide = 1'b0; pe = 1'b1; po = 1'b1;
      wr_char(9'h05A, 1'b1);
      rec_q.delete();
      exp_q.delete();
      push_ones(pre_len() + 1);
      push_frame(9'h05A);
      tx_en = 1'b1;
      step();
      while (!tdre) step();
      wr_char(9'h0C3, 1'b1);
      tx_en = 1'b0;
      step();
      check(txd_oe == 1'b1, "R9", "oe held during frame", txd_oe, 1);
      while (txd_oe) step();
      repeat (12) step();
      compare("R9 frame finishes, pending held back");
      check(tdre == 1'b0 && tidle == 1'b1, "R9", "tdre&tidle after stop", {tdre, tidle}, 1);
      check(txd_oe == 1'b0, "R9", "pin released", txd_oe, 0);

      // R10: re-enable sends the held character after a preamble
      rec_q.delete();
      exp_q.delete();
      push_ones(pre_len() + 1);
      push_frame(9'h0C3);
      tx_en = 1'b1;
      step();
      settle();
      compare("R10 held char after preamble");
      tx_en = 1'b0;
      step();

      // R10: toggling enable between characters inserts a preamble
      wide = 1'b1; pe = 1'b0;
      while (txd_oe) step();
      wr_char(9'h133, 1'b1);
      rec_q.delete();
      exp_q.delete();
      push_ones(pre_len() + 1);
      push_frame(9'h133);
      push_ones(pre_len());
      push_frame(9'h0CC);
      tx_en = 1'b1;
      step();
      while (!tdre) step();
      wr_char(9'h0CC, 1'b1);
      tx_en = 1'b0;
      step();
      tx_en = 1'b1;
      step();
      settle();
      compare("R10 preamble between characters");
      tx_en = 1'b0;
      step();

      // random formats and messages
      for (int it = 0; it < 24; it++) begin
         int n;
         while (txd_oe) step();
         wide = 1'($urandom % 2);
         pe   = 1'($urandom % 2);
         po   = 1'($urandom % 2);
         ie   = 1'($urandom % 2);
         n    = 1 + int'($urandom % 3);
         for (int k = 0; k < 4; k++) msg[k] = DW'($urandom);
         run_msg(n, "R2 R3 R4 R5 random message");
      end

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule